// File: doc/BRIEF.md
# DMA Command Decoder and Request Queue

This block sits beside a DMA controller and interprets 7-bit command words that an external device presents on the data bus while the controller runs in its external-command mode. Each accepted word is classified from its channel, mode and size fields. The result is one of four actions:

- start a data-bus handshake on channel 0;
- stop channel 0 by clearing its enable;
- flush every pending request;
- queue a transfer request for one of the channels 1 to 3.

The block keeps the channel 0 enable and request flags. It also keeps a small counted request queue for each of the other channels, with a sticky overflow bit per queue. The channel engines drain the queues through pop strobes. Software reaches the channel 0 enable through a write strobe. The data movement itself, the address and count registers, and bus arbitration live elsewhere. An end command leaves them untouched.

Top module: `dma_cmd_queue`

## Requirements
- R1: The command word carries the channel field in bits 6:5, the mode field in bits 4:3 and the size field in bits 2:0. A word is acted on only in a cycle where `cmd_valid` is high. A word with `cmd_valid` low changes nothing.
- R2: A word with channel 00, mode 00 and a size other than 101 or 110 sets `ch0_req` after the next clock edge. `ch0_ack` clears `ch0_req`.
- R3: A word with channel 00, a nonzero mode and size 111, while `ch0_busy` is low, clears `ch0_en` after the next edge. It leaves `ch0_req` and the queue counts unchanged.
- R4: The same end command arriving while `ch0_busy` is high is rejected, and `ch0_en` keeps its value.
- R5: A word with channel 00, mode 10 and size 110 clears `ch0_req` and every queue count after the next edge. The flush takes priority over pops or an acknowledge in the same cycle.
- R6: An accepted flush raises `freeze_clr` for exactly one cycle, after the same edge, only when `dma_mode_en` is high. Otherwise `freeze_clr` stays low.
- R7: A word whose channel field is n (1 to 3) adds one request to queue n, whatever its mode and size fields hold. The count of queue n is found at `q_count[3n-1:3n-3]`. Each queue holds 4 requests.
- R8: A request to a full queue is dropped and sets bit n-1 of `q_overflow`. That bit stays set until reset, including across flushes.
- R9: `q_pop[n-1]` removes one request from queue n. A pop on an empty queue has no effect. A push and a pop in the same cycle on a full queue leave it full with no overflow.
- R10: After reset, `ch0_en` is 0. A `ch0_en_wr` strobe loads `ch0_en_wdata` after the next edge. In the same cycle as an end command, the software write wins.
- R11: A channel-00 word that matches none of the patterns in R2, R3 and R5 has no effect. Examples are mode 01 with size 110, mode 00 with size 101, and mode 11 with size 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 7 | Command word: channel, mode and size fields |
| dma_mode_en | input | 1 | External-command mode enabled; gates the freeze-clear pulse |
| ch0_busy | input | 1 | Channel 0 transfer in progress |
| ch0_en_wr | input | 1 | Software write strobe for the channel 0 enable |
| ch0_en_wdata | input | 1 | Value written to the channel 0 enable |
| ch0_ack | input | 1 | Channel 0 request serviced |
| q_pop | input | 3 | Per-queue dequeue strobe, bit n-1 for channel n |
| ch0_en | output | 1 | Channel 0 enable |
| ch0_req | output | 1 | Channel 0 handshake request pending |
| freeze_clr | output | 1 | One-cycle pulse that releases a controller freeze |
| q_count | output | 9 | Three 3-bit request counts, channel 1 in the low bits |
| q_overflow | output | 3 | Sticky dropped-request flags, bit n-1 for channel n |

## Verification
The properties assume synchronous inputs that hold steady across each rising edge. They also assume a pop strobe on an empty queue is legal and harmless, so no input constraint is placed on it. The stimulus changes every input on the falling edge, one scenario at a time. Reset is held low for several cycles before any command is presented. This way, every `$past` reference in the properties falls within the cycles since reset.

// File: rtl/dcq_pkg.sv
// Shared field widths, command encodings and types for the DMA command
// decoder. Assumes a 7-bit command word: channel, mode, size (MSB first).
package dcq_pkg;
    localparam int ID_W   = 2;
    localparam int MODE_W = 2;
    localparam int SIZE_W = 3;
    localparam int WORD_W = ID_W + MODE_W + SIZE_W;

    localparam logic [MODE_W-1:0] MD_DATA  = 2'b00;
    localparam logic [MODE_W-1:0] MD_FLUSH = 2'b10;
    localparam logic [SIZE_W-1:0] SZ_RSVD  = 3'b101;
    localparam logic [SIZE_W-1:0] SZ_FLUSH = 3'b110;
    localparam logic [SIZE_W-1:0] SZ_END   = 3'b111;

    typedef enum logic [2:0] {
        K_NONE,
        K_HSHAKE,
        K_END,
        K_FLUSH,
        K_QUEUE
    } cmd_kind_t;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [MODE_W-1:0] mode;
        logic [SIZE_W-1:0] size;
    } cmd_word_t;
endpackage

// File: rtl/dcq_decode.sv
// Combinational classifier for one command word. Produces the action kind
// and the channel index. Assumes the word is meaningful only with valid high.
module dcq_decode
    import dcq_pkg::*;
(
    input  logic            cmd_valid,
    input  cmd_word_t       word,
    output cmd_kind_t       kind,
    output logic [ID_W-1:0] target
);
    // Pattern match; the checks are ordered so that overlapping size codes resolve.
    always_comb begin
        kind   = K_NONE;
        target = word.id;
        if (cmd_valid) begin
            if (word.id != '0) begin
                kind = K_QUEUE;
            end else if (word.mode == MD_DATA && word.size != SZ_RSVD
                         && word.size != SZ_FLUSH) begin
                kind = K_HSHAKE;
            end else if (word.mode == MD_FLUSH && word.size == SZ_FLUSH) begin
                kind = K_FLUSH;
            end else if (word.mode != MD_DATA && word.size == SZ_END) begin
                kind = K_END;
            end
        end
    end
endmodule

// File: rtl/dcq_ch0.sv
// Channel 0 state: enable, handshake request and the freeze-release pulse.
// Assumes the busy input reflects an in-flight channel 0 transfer.
module dcq_ch0
    import dcq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cmd_kind_t kind,
    input  logic      busy,
    input  logic      en_wr,
    input  logic      en_wdata,
    input  logic      ack,
    input  logic      mode_en,
    output logic      en,
    output logic      req,
    output logic      freeze_clr
);
    // Enable: a software write beats an end command; an end command is refused while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)                         en <= 1'b0;
        else if (en_wr)                     en <= en_wdata;
        else if (kind == K_END && !busy)    en <= 1'b0;
    end

    // Request: a flush clears it, a handshake sets it, an acknowledge retires it.
    always_ff @(posedge clk) begin
        if (!rst_n)                 req <= 1'b0;
        else if (kind == K_FLUSH)   req <= 1'b0;
        else if (kind == K_HSHAKE)  req <= 1'b1;
        else if (ack)               req <= 1'b0;
    end

    // Freeze release: a single-cycle pulse after a flush in external-command mode.
    always_ff @(posedge clk) begin
        if (!rst_n) freeze_clr <= 1'b0;
        else        freeze_clr <= (kind == K_FLUSH) && mode_en;
    end
endmodule

// File: rtl/dcq_queue.sv
// Counted request queue for one channel, with a sticky overflow flag.
// Assumes push, pop and flush are single-cycle strobes.
module dcq_queue #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    output logic [CNT_W-1:0] count,
    output logic             overflow
);
    logic full, empty, pop_ok, push_ok;

    // Acceptance: a pop needs an entry; a push needs room or a same-cycle pop.
    always_comb begin
        full    = (count == CNT_W'(DEPTH));
        empty   = (count == '0);
        pop_ok  = pop && !empty;
        push_ok = push && (!full || pop_ok);
    end

    // Occupancy: a flush empties the queue, otherwise apply the net push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (flush)   count <= '0;
        else if (push_ok && !pop_ok) count <= count + CNT_W'(1);
        else if (pop_ok && !push_ok) count <= count - CNT_W'(1);
    end

    // Overflow: latch once a request is dropped; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                     overflow <= 1'b0;
        else if (push && !push_ok)      overflow <= 1'b1;
    end
endmodule

// File: rtl/dma_cmd_queue.sv
// Top level: decodes external command words, keeps channel 0 flags and one
// request queue per remaining channel. Assumes NUM_Q equals 2**ID_W - 1.
module dma_cmd_queue
    import dcq_pkg::*;
#(
    parameter int QDEPTH = 4,
    parameter int NUM_Q  = 3,
    localparam int CNT_W = $clog2(QDEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic [WORD_W-1:0]      cmd_word,
    input  logic                   dma_mode_en,
    input  logic                   ch0_busy,
    input  logic                   ch0_en_wr,
    input  logic                   ch0_en_wdata,
    input  logic                   ch0_ack,
    input  logic [NUM_Q-1:0]       q_pop,
    output logic                   ch0_en,
    output logic                   ch0_req,
    output logic                   freeze_clr,
    output logic [NUM_Q*CNT_W-1:0] q_count,
    output logic [NUM_Q-1:0]       q_overflow
);
    cmd_kind_t       kind;
    logic [ID_W-1:0] target;
    logic            flush_all;

    dcq_decode u_decode (
        .cmd_valid (cmd_valid),
        .word      (cmd_word_t'(cmd_word)),
        .kind      (kind),
        .target    (target)
    );

    dcq_ch0 u_ch0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .busy       (ch0_busy),
        .en_wr      (ch0_en_wr),
        .en_wdata   (ch0_en_wdata),
        .ack        (ch0_ack),
        .mode_en    (dma_mode_en),
        .en         (ch0_en),
        .req        (ch0_req),
        .freeze_clr (freeze_clr)
    );

    // Flush strobe shared by all queues.
    always_comb flush_all = (kind == K_FLUSH);

    for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
        logic push;

        // Route a queue command to the channel it names (channel g+1).
        always_comb push = (kind == K_QUEUE) && (target == ID_W'(g + 1));

        dcq_queue #(.DEPTH(QDEPTH)) u_q (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (push),
            .pop      (q_pop[g]),
            .flush    (flush_all),
            .count    (q_count[g*CNT_W +: CNT_W]),
            .overflow (q_overflow[g])
        );
    end
endmodule

// File: rtl/dcq_checker.sv
// Port-level properties for dma_cmd_queue, attached by bind.
module dcq_checker
    import dcq_pkg::*;
#(
    parameter int QDEPTH = 4,
    parameter int NUM_Q  = 3,
    localparam int CNT_W = $clog2(QDEPTH + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmd_valid,
    input logic [WORD_W-1:0]      cmd_word,
    input logic                   dma_mode_en,
    input logic                   ch0_busy,
    input logic                   ch0_en_wr,
    input logic                   ch0_ack,
    input logic [NUM_Q-1:0]       q_pop,
    input logic                   ch0_en,
    input logic                   ch0_req,
    input logic                   freeze_clr,
    input logic [NUM_Q*CNT_W-1:0] q_count,
    input logic [NUM_Q-1:0]       q_overflow
);
    logic is_end, is_flush;
    always_comb begin
        is_end   = cmd_valid && cmd_word[6:5] == 2'b00 && cmd_word[4:3] != 2'b00
                   && cmd_word[2:0] == 3'b111;
        is_flush = cmd_valid && cmd_word == 7'b00_10_110;
    end

    // R3: an end command with channel 0 idle drops the enable
    p_end_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_end && !ch0_busy && !ch0_en_wr |=> !ch0_en);

    // R4: an end command during a transfer leaves the enable alone
    p_end_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_end && ch0_busy && !ch0_en_wr |=> $stable(ch0_en));

    // R5: a flush empties everything
    p_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_flush |=> (q_count == '0) && !ch0_req);

    // R6: the freeze release only follows a flush in external-command mode
    p_freeze_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_clr |-> $past(is_flush && dma_mode_en));

    // R6: the pulse lasts one cycle unless another flush arrives
    p_freeze_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_clr && !is_flush |=> !freeze_clr);

    // R8: overflow flags never fall outside reset
    p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|q_overflow) |=> ((q_overflow & $past(q_overflow)) == $past(q_overflow)));

    // R1: with no command and no other strobe, nothing moves
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid && q_pop == '0 && !ch0_ack && !ch0_en_wr
        |=> $stable(q_count) && $stable(ch0_en) && $stable(ch0_req));

    for (genvar g = 0; g < NUM_Q; g++) begin : g_bound
        // R7: no queue ever exceeds its depth
        p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
            q_count[g*CNT_W +: CNT_W] <= CNT_W'(QDEPTH));
    end
endmodule

bind dma_cmd_queue dcq_checker #(.QDEPTH(QDEPTH), .NUM_Q(NUM_Q)) u_dcq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_word    (cmd_word),
    .dma_mode_en (dma_mode_en),
    .ch0_busy    (ch0_busy),
    .ch0_en_wr   (ch0_en_wr),
    .ch0_ack     (ch0_ack),
    .q_pop       (q_pop),
    .ch0_en      (ch0_en),
    .ch0_req     (ch0_req),
    .freeze_clr  (freeze_clr),
    .q_count     (q_count),
    .q_overflow  (q_overflow)
);

// File: tb/test_dma_cmd_queue.sv
module test_dma_cmd_queue;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [6:0] cmd_word = '0;
    logic       dma_mode_en = 1'b0;
    logic       ch0_busy = 1'b0;
    logic       ch0_en_wr = 1'b0;
    logic       ch0_en_wdata = 1'b0;
    logic       ch0_ack = 1'b0;
    logic [2:0] q_pop = '0;
    logic       ch0_en, ch0_req, freeze_clr;
    logic [8:0] q_count;
    logic [2:0] q_overflow;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dma_cmd_queue i_dma_cmd_queue (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .dma_mode_en(dma_mode_en), .ch0_busy(ch0_busy), .ch0_en_wr(ch0_en_wr),
        .ch0_en_wdata(ch0_en_wdata), .ch0_ack(ch0_ack), .q_pop(q_pop),
        .ch0_en(ch0_en), .ch0_req(ch0_req), .freeze_clr(freeze_clr),
        .q_count(q_count), .q_overflow(q_overflow)
    );

    localparam logic [6:0] W_FLUSH = 7'b00_10_110;

    function automatic int cnt(input int ch);
        return int'(q_count[(ch-1)*3 +: 3]);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs from a falling edge; return on the next falling edge.
    task automatic step(input logic v, input logic [6:0] w, input logic [2:0] pop,
                        input logic ack, input logic wr, input logic wd);
        cmd_valid = v; cmd_word = w; q_pop = pop;
        ch0_ack = ack; ch0_en_wr = wr; ch0_en_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_word = '0; q_pop = '0;
        ch0_ack = 1'b0; ch0_en_wr = 1'b0; ch0_en_wdata = 1'b0;
    endtask

    task automatic cmd(input logic [6:0] w);
        step(1'b1, w, 3'b000, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset;
        check("R10 reset en", int'(ch0_en), 0);
        check("R2 reset req", int'(ch0_req), 0);
        check("R7 reset counts", int'(q_count), 0);
        check("R8 reset ovf", int'(q_overflow), 0);
        check("R6 reset freeze", int'(freeze_clr), 0);
    endtask

    task automatic t_handshake;
        cmd(7'b00_00_000);
        check("R2 hs size000", int'(ch0_req), 1);
        step(1'b0, '0, 3'b000, 1'b1, 1'b0, 1'b0);
        check("R2 ack clears", int'(ch0_req), 0);
        cmd(7'b00_00_111);
        check("R2 hs size111", int'(ch0_req), 1);
        step(1'b0, '0, 3'b000, 1'b1, 1'b0, 1'b0);
        cmd(7'b00_00_100);
        check("R2 hs size100", int'(ch0_req), 1);
        step(1'b0, '0, 3'b000, 1'b1, 1'b0, 1'b0);
        check("R2 ack again", int'(ch0_req), 0);
    endtask

    task automatic t_unmatched;
        cmd(7'b00_01_110);
        check("R11 md01 sz110 req", int'(ch0_req), 0);
        cmd(7'b00_00_101);
        check("R11 md00 sz101 req", int'(ch0_req), 0);
        cmd(7'b00_11_000);
        check("R11 md11 sz000 req", int'(ch0_req), 0);
        check("R11 counts", int'(q_count), 0);
        check("R11 en", int'(ch0_en), 0);
    endtask

    task automatic t_end;
        step(1'b0, '0, 3'b000, 1'b0, 1'b1, 1'b1);
        check("R10 write en", int'(ch0_en), 1);
        cmd(7'b00_01_111);
        check("R3 end clears en", int'(ch0_en), 0);
        check("R3 req kept", int'(ch0_req), 0);
        cmd(7'b00_00_000);
        step(1'b0, '0, 3'b000, 1'b0, 1'b1, 1'b1);
        cmd(7'b00_11_111);
        check("R3 md11 end clears", int'(ch0_en), 0);
        check("R3 req still set", int'(ch0_req), 1);
        step(1'b0, '0, 3'b000, 1'b1, 1'b0, 1'b0);
        step(1'b0, '0, 3'b000, 1'b0, 1'b1, 1'b1);
        ch0_busy = 1'b1;
        cmd(7'b00_10_111);
        check("R4 end refused busy", int'(ch0_en), 1);
        ch0_busy = 1'b0;
        step(1'b1, 7'b00_01_111, 3'b000, 1'b0, 1'b1, 1'b1);
        check("R10 write beats end", int'(ch0_en), 1);
        step(1'b0, '0, 3'b000, 1'b0, 1'b1, 1'b0);
        check("R10 write zero", int'(ch0_en), 0);
    endtask

    task automatic t_queue;
        cmd(7'b01_00_000);
        cmd(7'b01_11_101);
        check("R7 ch1 two", cnt(1), 2);
        check("R7 ch2 zero", cnt(2), 0);
        cmd(7'b11_10_110);
        check("R7 ch3 flush-like bits", cnt(3), 1);
        check("R7 ch1 untouched", cnt(1), 2);
        check("R7 req untouched", int'(ch0_req), 0);
    endtask

    task automatic t_pop;
        step(1'b0, '0, 3'b001, 1'b0, 1'b0, 1'b0);
        check("R9 pop one", cnt(1), 1);
        step(1'b0, '0, 3'b001, 1'b0, 1'b0, 1'b0);
        step(1'b0, '0, 3'b001, 1'b0, 1'b0, 1'b0);
        check("R9 pop empty", cnt(1), 0);
        check("R9 ch3 kept", cnt(3), 1);
    endtask

    task automatic t_overflow;
        for (int i = 0; i < 5; i++) cmd(7'b10_00_000);
        check("R8 ch2 full", cnt(2), 4);
        check("R8 ovf bit1", int'(q_overflow), 2);
        step(1'b0, '0, 3'b010, 1'b0, 1'b0, 1'b0);
        check("R8 pop after ovf", cnt(2), 3);
        check("R8 ovf sticky", int'(q_overflow), 2);
    endtask

    task automatic t_full_pushpop;
        for (int i = 0; i < 3; i++) cmd(7'b11_01_010);
        check("R9 ch3 full", cnt(3), 4);
        step(1'b1, 7'b11_00_000, 3'b100, 1'b0, 1'b0, 1'b0);
        check("R9 push pop full", cnt(3), 4);
        check("R9 no ovf", int'(q_overflow), 2);
    endtask

    task automatic t_novalid;
        step(1'b0, W_FLUSH, 3'b000, 1'b0, 1'b0, 1'b0);
        check("R1 ch2 kept", cnt(2), 3);
        check("R1 ch3 kept", cnt(3), 4);
        step(1'b0, 7'b01_00_000, 3'b000, 1'b0, 1'b0, 1'b0);
        check("R1 no push", cnt(1), 0);
    endtask

    task automatic t_flush;
        cmd(7'b00_00_001);
        cmd(7'b01_00_000);
        dma_mode_en = 1'b0;
        step(1'b1, W_FLUSH, 3'b111, 1'b0, 1'b0, 1'b0);
        check("R5 counts zero", int'(q_count), 0);
        check("R5 req zero", int'(ch0_req), 0);
        check("R6 no pulse mode off", int'(freeze_clr), 0);
        cmd(7'b01_00_000);
        dma_mode_en = 1'b1;
        cmd(W_FLUSH);
        check("R6 pulse", int'(freeze_clr), 1);
        check("R5 ch1 cleared", cnt(1), 0);
        step(1'b0, '0, 3'b000, 1'b0, 1'b0, 1'b0);
        check("R6 pulse ends", int'(freeze_clr), 0);
        check("R8 ovf survives flush", int'(q_overflow), 2);
        dma_mode_en = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_handshake();
        t_unmatched();
        t_end();
        t_queue();
        t_pop();
        t_overflow();
        t_full_pushpop();
        t_novalid();
        t_flush();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule